// File: doc/BRIEF.md
# Resumable Array Self-Test Controller

This controller sequences a built-in self-test across on-chip memory arrays grouped into banks. Software starts a run by writing a 64-bit control/status word that names a starting bank and a bitmask of arrays that still need testing. The controller then hands one array at a time to a per-array tester, which here is a stub with a done/fail handshake. It clears each mask bit as the matching array passes and moves on to later banks until a configured final bank is done.

The control/status word always shows live progress. If an abort request stops a run, the word holds the exact resume point: the pending mask and the current bank. Software writes it back to carry on. A failing array sets the result flag and ends the run at once. The mask and bank are kept as they were, so the failing array can be identified.

Top module: `array_selftest_ctrl`

## Requirements
- R1: After reset the control/status word reads zero, and `busy` and `test_req` are low.
- R2: Word layout: bits 31:0 hold the pending mask, bits 47:32 the bank, bit 63 the result flag, and bits 62:48 always read zero. Mask bits at or above ARR_PER_BANK read zero because they are dropped on write.
- R3: A write while idle loads mask, bank and result flag. If bit 63 is clear, a run starts and `busy` is high on the next cycle. If bit 63 is set, the fields load and no run starts.
- R4: Within a bank, arrays are requested in ascending bit order, one request per pending mask bit. `test_bank` and `test_idx` name the array under test.
- R5: A passing array has its mask bit cleared on the clock edge that samples `test_done` with `test_fail` low. During a run the word reads back live mask and bank.
- R6: When the mask is empty and the bank is below LAST_BANK, the bank increments and the mask reloads to all ones. At or above LAST_BANK the run ends with the mask zero and bit 63 clear.
- R7: A failing array sets bit 63 and ends the run at once. The mask, including the failing array's bit, and the bank stay unchanged.
- R8: `abort_req` is acted on only between arrays, never during an array test. The run then stops with the pending mask and bank in the word, and writing that word back resumes the run.
- R9: Writes to the control/status word while `busy` is high have no effect.
- R10: `busy` is high from the cycle after a starting write until the run completes, aborts or fails.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_wr_en | input | 1 | Write strobe for the control/status word |
| csr_wr_data | input | 64 | Word to write |
| csr_rd_data | output | 64 | Live control/status word |
| busy | output | 1 | Run in progress |
| abort_req | input | 1 | Request to stop at the next array boundary |
| test_req | output | 1 | Array test in progress |
| test_bank | output | 16 | Bank of the array under test |
| test_idx | output | IDX_W | Index of the array under test |
| test_done | input | 1 | Tester reports a finished array |
| test_fail | input | 1 | Tester verdict, qualified by test_done |

## Verification
The bench builds the controller with eight arrays per bank and a final bank of 3. This keeps a full sweep short, so every run can cross several bank rollovers. Starting banks are drawn from 0 to 4, which reaches both the final bank and starting points past it. A failing array, an abort after a chosen number of passes and an abort followed by write-back all fit within a few hundred cycles per run.

// File: rtl/abist_pkg.sv
package abist_pkg;

    localparam int CSR_W  = 64;
    localparam int MASK_W = 32;
    localparam int BANK_W = 16;
    localparam int RSVD_W = CSR_W - MASK_W - BANK_W - 1;

    typedef struct packed {
        logic              result;
        logic [RSVD_W-1:0] rsvd;
        logic [BANK_W-1:0] bank;
        logic [MASK_W-1:0] mask;
    } csr_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PICK,
        ST_TEST
    } st_t;

endpackage

// File: rtl/abist_lowbit.sv
module abist_lowbit #(
    parameter int W  = 32,
    parameter int IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  vec,
    output logic          any,
    output logic [IW-1:0] idx
);
    logic [W:0]   seen;
    logic [W-1:0] hot;

    assign seen[0] = 1'b0;

    for (genvar g = 0; g < W; g++) begin : g_chain
        assign seen[g+1] = seen[g] | vec[g];
        assign hot[g]    = vec[g] & ~seen[g];
    end

    assign any = seen[W];

    always_comb begin
        idx = '0;
        for (int i = 0; i < W; i++) begin
            if (hot[i]) idx = idx | IW'(i);
        end
    end
endmodule

// File: rtl/abist_csr_pack.sv
module abist_csr_pack
    import abist_pkg::*;
#(
    parameter int APB = 32
) (
    input  logic [APB-1:0]    mask,
    input  logic [BANK_W-1:0] bank,
    input  logic              result,
    output logic [CSR_W-1:0]  word
);
    csr_t w;

    always_comb begin
        w        = '0;
        w.mask   = MASK_W'(mask);
        w.bank   = bank;
        w.result = result;
    end

    assign word = w;
endmodule

// File: rtl/array_selftest_ctrl.sv
module array_selftest_ctrl
    import abist_pkg::*;
#(
    parameter int ARR_PER_BANK = 32,
    parameter int LAST_BANK    = 15,
    parameter int IDX_W        = (ARR_PER_BANK > 1) ? $clog2(ARR_PER_BANK) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              csr_wr_en,
    input  logic [CSR_W-1:0]  csr_wr_data,
    output logic [CSR_W-1:0]  csr_rd_data,
    output logic              busy,
    input  logic              abort_req,
    output logic              test_req,
    output logic [BANK_W-1:0] test_bank,
    output logic [IDX_W-1:0]  test_idx,
    input  logic              test_done,
    input  logic              test_fail
);
    localparam logic [ARR_PER_BANK-1:0] ALL_ONES = {ARR_PER_BANK{1'b1}};
    localparam logic [BANK_W-1:0]       FINAL_BANK = BANK_W'(LAST_BANK);

    st_t                     st;
    logic [ARR_PER_BANK-1:0] mask_q;
    logic [BANK_W-1:0]       bank_q;
    logic                    result_q;
    logic [IDX_W-1:0]        idx_q;

    csr_t                    wr_word;
    logic                    pick_any;
    logic [IDX_W-1:0]        pick_idx;

    assign wr_word = csr_t'(csr_wr_data);

    logic unused_rsvd;
    assign unused_rsvd = ^wr_word.rsvd;

    if (ARR_PER_BANK < MASK_W) begin : g_drop_high
        logic unused_high;
        assign unused_high = ^wr_word.mask[MASK_W-1:ARR_PER_BANK];
    end

    abist_lowbit #(
        .W  (ARR_PER_BANK),
        .IW (IDX_W)
    ) u_pick (
        .vec (mask_q),
        .any (pick_any),
        .idx (pick_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            mask_q   <= '0;
            bank_q   <= '0;
            result_q <= 1'b0;
            idx_q    <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (csr_wr_en) begin
                        mask_q   <= wr_word.mask[ARR_PER_BANK-1:0];
                        bank_q   <= wr_word.bank;
                        result_q <= wr_word.result;
                        if (!wr_word.result) st <= ST_PICK;
                    end
                end
                ST_PICK: begin
                    if (abort_req) begin
                        st <= ST_IDLE;
                    end else if (pick_any) begin
                        idx_q <= pick_idx;
                        st    <= ST_TEST;
                    end else if (bank_q >= FINAL_BANK) begin
                        st <= ST_IDLE;
                    end else begin
                        bank_q <= bank_q + 1'b1;
                        mask_q <= ALL_ONES;
                    end
                end
                ST_TEST: begin
                    if (test_done) begin
                        if (test_fail) begin
                            result_q <= 1'b1;
                            st       <= ST_IDLE;
                        end else begin
                            mask_q[idx_q] <= 1'b0;
                            st            <= ST_PICK;
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign busy      = (st != ST_IDLE);
    assign test_req  = (st == ST_TEST);
    assign test_bank = bank_q;
    assign test_idx  = idx_q;

    abist_csr_pack #(
        .APB (ARR_PER_BANK)
    ) u_pack (
        .mask   (mask_q),
        .bank   (bank_q),
        .result (result_q),
        .word   (csr_rd_data)
    );
endmodule

// File: rtl/array_selftest_ctrl_chk.sv
module array_selftest_ctrl_chk #(
    parameter int IDX_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             csr_wr_en,
    input logic [63:0]      csr_wr_data,
    input logic [63:0]      csr_rd_data,
    input logic             busy,
    input logic             test_req,
    input logic [IDX_W-1:0] test_idx,
    input logic             test_done,
    input logic             test_fail
);
    // R10
    busy_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(csr_wr_en));

    // R3
    start_on_write_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && csr_wr_en && !csr_wr_data[63]) |=> busy);

    // R3
    load_no_start_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && csr_wr_en && csr_wr_data[63]) |=> (!busy && csr_rd_data[63]));

    // R5
    pass_clears_bit_chk: assert property (@(posedge clk) disable iff (rst)
        (test_req && test_done && !test_fail) |=> (csr_rd_data[$past(test_idx)] == 1'b0));

    // R7
    fail_stops_chk: assert property (@(posedge clk) disable iff (rst)
        (test_req && test_done && test_fail) |=> (!busy && csr_rd_data[63]
            && csr_rd_data[31:0] == $past(csr_rd_data[31:0])));

    // R8
    test_not_cut_chk: assert property (@(posedge clk) disable iff (rst)
        (test_req && !test_done) |=> (test_req && $stable(test_idx)));

    // R9
    busy_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (test_req && !test_done && csr_wr_en) |=> $stable(csr_rd_data));

    // R4
    req_inside_run_chk: assert property (@(posedge clk) disable iff (rst)
        test_req |-> busy);
endmodule

bind array_selftest_ctrl array_selftest_ctrl_chk #(
    .IDX_W (IDX_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .csr_wr_en   (csr_wr_en),
    .csr_wr_data (csr_wr_data),
    .csr_rd_data (csr_rd_data),
    .busy        (busy),
    .test_req    (test_req),
    .test_idx    (test_idx),
    .test_done   (test_done),
    .test_fail   (test_fail)
);

// File: tb/array_selftest_ctrl_bench.sv
module array_selftest_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int APB        = 8;
    localparam int LAST       = 3;
    localparam int IW         = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        csr_wr_en = 1'b0;
    logic [63:0] csr_wr_data = '0;
    logic [63:0] csr_rd_data;
    logic        busy;
    logic        abort_req = 1'b0;
    logic        test_req;
    logic [15:0] test_bank;
    logic [IW-1:0] test_idx;
    logic        test_done = 1'b0;
    logic        test_fail = 1'b0;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    array_selftest_ctrl #(
        .ARR_PER_BANK (APB),
        .LAST_BANK    (LAST)
    ) u_array_selftest_ctrl (
        .clk         (clk),
        .rst         (rst),
        .csr_wr_en   (csr_wr_en),
        .csr_wr_data (csr_wr_data),
        .csr_rd_data (csr_rd_data),
        .busy        (busy),
        .abort_req   (abort_req),
        .test_req    (test_req),
        .test_bank   (test_bank),
        .test_idx    (test_idx),
        .test_done   (test_done),
        .test_fail   (test_fail)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] pack(input logic [APB-1:0] m, input int b, input bit r);
        return {r, 15'b0, 16'(b), 24'b0, m};
    endfunction

    function automatic int lowest(input logic [APB-1:0] m);
        for (int i = 0; i < APB; i++) if (m[i]) return i;
        return -1;
    endfunction

    // One run: starts at a negedge, returns at a negedge after busy falls.
    task automatic do_run(input logic [63:0] word, input bit fail_en, input int fail_bank,
                          input int fail_idx, input int abort_k, input bit busy_wr,
                          output logic [63:0] final_word, output int tests);
        logic [APB-1:0] e_mask;
        int  e_bank;
        bit  e_res;
        bit  prev_req;
        int  cnt;
        int  guard;
        csr_wr_en   = 1'b1;
        csr_wr_data = word;
        @(negedge clk);
        csr_wr_en = 1'b0;
        chk(busy === 1'b1, "R10 busy after start", 64'(busy), 64'd1);
        e_mask   = word[APB-1:0];
        e_bank   = int'(word[47:32]);
        e_res    = 1'b0;
        prev_req = 1'b0;
        cnt      = 0;
        guard    = 0;
        tests    = 0;
        while (1) begin
            csr_wr_en = 1'b0;
            test_done = 1'b0;
            test_fail = 1'b0;
            if (!busy) break;
            if (test_req && !prev_req) begin
                while (e_mask == '0 && e_bank < LAST) begin
                    e_bank++;
                    e_mask = '1;
                end
                // R4: ascending order, bank and index of the next pending array
                chk(e_mask != '0 && int'(test_idx) == lowest(e_mask) && int'(test_bank) == e_bank,
                    "R4 order", {test_bank, 13'b0, test_idx}, {16'(e_bank), 16'(lowest(e_mask))});
                // R5: live progress readable during the run
                chk(csr_rd_data == pack(e_mask, e_bank, 1'b0), "R5 live word",
                    csr_rd_data, pack(e_mask, e_bank, 1'b0));
                tests++;
                cnt = int'($urandom_range(0, 3));
                if (abort_k == tests) abort_req = 1'b1;
                if (busy_wr && tests == 1) begin
                    csr_wr_en   = 1'b1;
                    csr_wr_data = {1'b0, 15'h0, 16'h0002, 32'h0000_0003};
                end
            end
            if (test_req) begin
                if (cnt == 0) begin
                    test_done = 1'b1;
                    test_fail = fail_en && int'(test_bank) == fail_bank && int'(test_idx) == fail_idx;
                    if (test_fail) e_res = 1'b1;
                    else e_mask[test_idx] = 1'b0;
                end else begin
                    cnt--;
                end
            end
            prev_req = test_req;
            guard++;
            if (guard > 3000) begin
                chk(1'b0, "R10 run end", 64'(busy), 64'd0);
                break;
            end
            @(negedge clk);
        end
        abort_req = 1'b0;
        final_word = csr_rd_data;
        // R6 R7 R8 R9: word at end of run
        chk(csr_rd_data == pack(e_mask, e_bank, e_res), "R6/R7/R8/R9 final word",
            csr_rd_data, pack(e_mask, e_bank, e_res));
        chk(test_req === 1'b0, "R10 idle after run", 64'(test_req), 64'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        errors++;
        $display("FAIL R10 watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [63:0] fw;
        logic [63:0] w;
        int          nt;
        void'($urandom(32'd5151));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(csr_rd_data == 64'd0, "R1 word", csr_rd_data, 64'd0);
        chk(busy == 1'b0 && test_req == 1'b0, "R1 busy/req", {busy, test_req}, 64'd0);

        // R2 R3: load with result set, reserved and high mask bits dropped, no start
        csr_wr_en   = 1'b1;
        csr_wr_data = {1'b1, 15'h7FFF, 16'h1234, 32'hFFFF_FFFF};
        @(negedge clk);
        csr_wr_en = 1'b0;
        chk(csr_rd_data == {1'b1, 15'h0, 16'h1234, 32'h0000_00FF}, "R2 layout",
            csr_rd_data, {1'b1, 15'h0, 16'h1234, 32'h0000_00FF});
        chk(busy == 1'b0, "R3 no start with bit63", 64'(busy), 64'd0);

        // R6: full sweep from bank 0
        do_run({1'b0, 15'h0, 16'd0, 32'hFF}, 1'b0, 0, 0, 0, 1'b0, fw, nt);
        chk(nt == 32, "R6 array count", 64'(nt), 64'd32);
        chk(fw == pack('0, LAST, 1'b0), "R6 sweep end", fw, pack('0, LAST, 1'b0));

        // R4: sparse mask at final bank
        do_run({1'b0, 15'h0, 16'd3, 32'h24}, 1'b0, 0, 0, 0, 1'b0, fw, nt);
        chk(nt == 2, "R4 sparse count", 64'(nt), 64'd2);

        // R6: start beyond final bank with empty mask
        do_run({1'b0, 15'h0, 16'd5, 32'h0}, 1'b0, 0, 0, 0, 1'b0, fw, nt);
        chk(nt == 0, "R6 empty run", 64'(nt), 64'd0);

        // R7: failure at first tested array
        do_run({1'b0, 15'h0, 16'd1, 32'hF0}, 1'b1, 1, 4, 0, 1'b0, fw, nt);
        chk(fw == {1'b1, 15'h0, 16'd1, 32'hF0}, "R7 fail word", fw, {1'b1, 15'h0, 16'd1, 32'hF0});

        // R8: abort after three arrays then resume
        do_run({1'b0, 15'h0, 16'd2, 32'hFF}, 1'b0, 0, 0, 3, 1'b0, fw, nt);
        chk(nt == 3 && fw == pack(8'hF8, 2, 1'b0), "R8 abort point", fw, pack(8'hF8, 2, 1'b0));
        w = fw;
        w[63] = 1'b0;
        do_run(w, 1'b0, 0, 0, 0, 1'b0, fw, nt);
        chk(nt == 13 && fw == pack('0, LAST, 1'b0), "R8 resumed end", fw, pack('0, LAST, 1'b0));

        // R9: write during busy ignored
        do_run({1'b0, 15'h0, 16'd3, 32'hC0}, 1'b0, 0, 0, 0, 1'b1, fw, nt);
        chk(nt == 2 && fw == pack('0, 3, 1'b0), "R9 busy write", fw, pack('0, 3, 1'b0));

        // Random runs, resuming after aborts
        w = '0;
        for (int r = 0; r < 40; r++) begin
            bit fe;
            int fb;
            int fi;
            int ak;
            if (w == '0) begin
                w = {1'b0, 15'($urandom), 16'($urandom_range(0, 4)), 32'($urandom)};
            end
            fe = ($urandom_range(0, 3) == 0);
            fb = int'(w[47:32]) + int'($urandom_range(0, 1));
            fi = int'($urandom_range(0, APB - 1));
            ak = ($urandom_range(0, 3) == 0) ? int'($urandom_range(1, 4)) : 0;
            do_run(w, fe, fb, fi, ak, ($urandom_range(0, 4) == 0), fw, nt);
            if (ak != 0 && !fw[63] && fw[APB-1:0] != '0) begin
                w = fw;
                w[63] = 1'b0;
            end else begin
                w = '0;
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule